// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block holds the programmer-visible register state of a small 16-bit processor. Seven registers are banked and exist twice: four data registers D0..D3, two address registers X0 and X1, and the frame base FBASE. The other six are single and shared by both banks: the 20-bit program counter PCNT, the 20-bit vector table base VBASE, the user and interrupt stack pointers USTK and ISTK, the static base SBASE and the flag word FLAGS. The banked copy in use is picked by the bank flag inside FLAGS. Writing FLAGS therefore switches every banked register at once. Nothing is copied between banks, and the contents of the inactive bank are kept.

Two combinational read ports and one write port share one access format. Each port takes a 4-bit register selector and a 2-bit access size. The sizes are full word, low byte, high byte and 32-bit pair. Byte access is allowed only on D0 and D1. Pair access joins D2:D0, D3:D1 and X1:X0. The instruction decoder, ALU and interrupt sequencer sit around this block and drive its ports. A flag update is simply a word write to FLAGS.

Top module: `dual_bank_rf`

## Requirements
- R1: After reset every register reads zero, and the active bank is bank 0.
- R2: Selector codes are D0=0, D1=1, D2=2, D3=3, X0=4, X1=5, FBASE=6, PCNT=7, VBASE=8, USTK=9, ISTK=10, SBASE=11, FLAGS=12. Size codes are word=0, low byte=1, high byte=2, pair=3. A word access to a banked register reads or writes bits 15:0 of the active bank's copy, and read bits 31:16 are zero.
- R3: Byte access is legal on D0 and D1. A low-byte write loads bits 7:0 from bus bits 7:0. A high-byte write loads bits 15:8 from bus bits 7:0. The other half of the register is left unchanged. A byte read returns the selected half on bits 7:0, with bits 31:8 zero.
- R4: A pair access with selector D0, D1 or X0 covers D2:D0, D3:D1 or X1:X0. The second-named register is bits 15:0 and the partner is bits 31:16. A pair write updates both halves in the same clock cycle.
- R5: The active bank is FLAGS bit 4. After a change of that bit, the next access sees the other bank. The values held in the inactive bank never change.
- R6: Shared registers read the same in either bank. PCNT and VBASE keep bus bits 19:0 and read with bits 31:20 zero. USTK, ISTK and SBASE keep bits 15:0.
- R7: FLAGS stores carry bit 0, debug bit 1, zero bit 2, sign bit 3, bank bit 4, overflow bit 5, interrupt-enable bit 6, stack-select bit 7 and priority level bits 14:12. All other bits always read zero.
- R8: A read of a register in the cycle it is written returns the old value. The new value appears after the clock edge.
- R9: An illegal combination changes no register, and a read with it returns zero. The illegal combinations are a byte access to any register other than D0 or D1, a pair access with any selector other than D0, D1 or X0, and a selector of 13 to 15.
- R10: The two read ports are independent and can read different registers with different sizes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_sel | input | 4 | Read port 0 register selector |
| rd0_size | input | 2 | Read port 0 access size |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_sel | input | 4 | Read port 1 register selector |
| rd1_size | input | 2 | Read port 1 access size |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write register selector |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data |
| bank_act | output | 1 | Active bank (FLAGS bit 4) |

## Verification
A corrupted banked register stays hidden until its bank is made active again. For that reason the bench fills both banks with distinct values, switches back, and reads every register. This exposes a lost or cross-written copy within two cycles of the switch. A byte-merge fault shows on the very next read of the untouched half. A pair fault shows on the next word read of the partner register. Stuck or unmasked FLAGS bits show at once on a FLAGS read and on `bank_act`.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DW    = 16;
  localparam int PCW   = 20;
  localparam int BUSW  = 32;
  localparam int NBANK = 2;
  localparam int NBREG = 7;

  localparam logic [3:0] S_D0 = 4'd0, S_D1 = 4'd1, S_D2 = 4'd2, S_D3 = 4'd3;
  localparam logic [3:0] S_X0 = 4'd4, S_X1 = 4'd5, S_FB = 4'd6;
  localparam logic [3:0] S_PC = 4'd7, S_VB = 4'd8, S_US = 4'd9;
  localparam logic [3:0] S_IS = 4'd10, S_SB = 4'd11, S_FL = 4'd12;

  localparam logic [1:0] Z_WORD = 2'd0, Z_LO = 2'd1, Z_HI = 2'd2, Z_PAIR = 2'd3;

  localparam logic [DW-1:0] FLAG_MASK = 16'h70FF;
  localparam int FLAG_BANK_BIT = 4;

  function automatic logic byte_ok(input logic [3:0] s);
    return (s == S_D0) || (s == S_D1);
  endfunction

  function automatic logic pair_ok(input logic [3:0] s);
    return (s == S_D0) || (s == S_D1) || (s == S_X0);
  endfunction

  function automatic logic access_ok(input logic [3:0] s, input logic [1:0] z);
    case (z)
      Z_WORD:  return s <= S_FL;
      Z_LO:    return byte_ok(s);
      Z_HI:    return byte_ok(s);
      default: return pair_ok(s);
    endcase
  endfunction

  function automatic logic [3:0] pair_partner(input logic [3:0] s);
    case (s)
      S_D0:    return S_D2;
      S_D1:    return S_D3;
      S_X0:    return S_X1;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge16(input logic [DW-1:0] old,
                                            input logic [DW-1:0] d,
                                            input logic [1:0] z);
    case (z)
      Z_LO:    return {old[DW-1:8], d[7:0]};
      Z_HI:    return {d[7:0], old[7:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [BUSW-1:0] extract16(input logic [DW-1:0] v, input logic [1:0] z);
    case (z)
      Z_LO:    return {{(BUSW-8){1'b0}}, v[7:0]};
      Z_HI:    return {{(BUSW-8){1'b0}}, v[15:8]};
      default: return {{(BUSW-DW){1'b0}}, v};
    endcase
  endfunction
endpackage

// File: rtl/rf_banked.sv
module rf_banked
  import rf_pkg::*;
#(
  parameter int NB = NBANK,
  parameter int NR = NBREG,
  parameter int W  = DW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(NB)-1:0]         bank_sel,
  input  logic                          wr_go,
  input  logic [3:0]                    wr_sel,
  input  logic [1:0]                    wr_size,
  input  logic [2*W-1:0]                wr_data,
  output logic [NB-1:0][NR-1:0][W-1:0]  q,
  output logic [NR-1:0]                 we_vec
);
  localparam int BS = $clog2(NB);

  logic [NR-1:0][W-1:0] cur;
  logic [NR-1:0][W-1:0] nv;

  assign cur = q[bank_sel];

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      we_vec[r] = 1'b0;
      nv[r]     = cur[r];
      if (wr_go && wr_sel == 4'(r)) begin
        we_vec[r] = 1'b1;
        nv[r]     = merge16(cur[r], wr_data[W-1:0], wr_size);
      end
      if (wr_go && wr_size == Z_PAIR && pair_partner(wr_sel) == 4'(r)) begin
        we_vec[r] = 1'b1;
        nv[r]     = wr_data[2*W-1:W];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < NR; r++) begin
        if (!rst_n)
          q[b][r] <= '0;
        else if (we_vec[r] && bank_sel == BS'(b))
          q[b][r] <= nv[r];
      end
    end
  end
endmodule

// File: rtl/rf_shared.sv
module rf_shared
  import rf_pkg::*;
#(
  parameter int W  = DW,
  parameter int PW = PCW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic [3:0]    wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] pc_q,
  output logic [PW-1:0] vb_q,
  output logic [W-1:0]  us_q,
  output logic [W-1:0]  is_q,
  output logic [W-1:0]  sb_q,
  output logic [W-1:0]  fl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      vb_q <= '0;
      us_q <= '0;
      is_q <= '0;
      sb_q <= '0;
      fl_q <= '0;
    end else if (wr_go) begin
      case (wr_sel)
        S_PC:    pc_q <= wr_data;
        S_VB:    vb_q <= wr_data;
        S_US:    us_q <= wr_data[W-1:0];
        S_IS:    is_q <= wr_data[W-1:0];
        S_SB:    sb_q <= wr_data[W-1:0];
        S_FL:    fl_q <= wr_data[W-1:0] & FLAG_MASK;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport
  import rf_pkg::*;
#(
  parameter int NR = NBREG,
  parameter int W  = DW,
  parameter int PW = PCW,
  parameter int BW = BUSW
) (
  input  logic [3:0]            sel,
  input  logic [1:0]            size,
  input  logic [NR-1:0][W-1:0]  act,
  input  logic [PW-1:0]         pc_q,
  input  logic [PW-1:0]         vb_q,
  input  logic [W-1:0]          us_q,
  input  logic [W-1:0]          is_q,
  input  logic [W-1:0]          sb_q,
  input  logic [W-1:0]          fl_q,
  output logic [BW-1:0]         data
);
  always_comb begin
    data = '0;
    if (access_ok(sel, size)) begin
      if (sel < 4'(NR)) begin
        data = extract16(act[sel[2:0]], size);
        if (size == Z_PAIR)
          data[BW-1:W] = act[pair_partner(sel)];
      end else begin
        case (sel)
          S_PC:    data = BW'(pc_q);
          S_VB:    data = BW'(vb_q);
          S_US:    data = BW'(us_q);
          S_IS:    data = BW'(is_q);
          S_SB:    data = BW'(sb_q);
          default: data = BW'(fl_q);
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_bank_rf.sv
module dual_bank_rf
  import rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd0_sel,
  input  logic [1:0]  rd0_size,
  output logic [31:0] rd0_data,
  input  logic [3:0]  rd1_sel,
  input  logic [1:0]  rd1_size,
  output logic [31:0] rd1_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_data,
  output logic        bank_act
);
  localparam int NRD = 2;

  logic [NBANK-1:0][NBREG-1:0][DW-1:0] bank_q;
  logic [NBREG-1:0]                    we_vec;
  logic [PCW-1:0] pc_q, vb_q;
  logic [DW-1:0]  us_q, is_q, sb_q, fl_q;
  logic           bank;

  // Named internal events for the checker
  logic wr_legal, wr_illegal, wr_banked, wr_shared;
  assign wr_legal   = wr_en && access_ok(wr_sel, wr_size);
  assign wr_illegal = wr_en && !access_ok(wr_sel, wr_size);
  assign wr_banked  = wr_legal && (wr_sel < 4'(NBREG));
  assign wr_shared  = wr_legal && (wr_sel >= 4'(NBREG));

  assign bank     = fl_q[FLAG_BANK_BIT];
  assign bank_act = bank;

  rf_banked u_bank (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank), .wr_go(wr_banked),
    .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
    .q(bank_q), .we_vec(we_vec)
  );

  rf_shared u_shr (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_shared), .wr_sel(wr_sel),
    .wr_data(wr_data[PCW-1:0]),
    .pc_q(pc_q), .vb_q(vb_q), .us_q(us_q), .is_q(is_q), .sb_q(sb_q), .fl_q(fl_q)
  );

  logic [NRD-1:0][3:0]  rsel;
  logic [NRD-1:0][1:0]  rsize;
  logic [NRD-1:0][31:0] rdata;
  assign rsel  = {rd1_sel, rd0_sel};
  assign rsize = {rd1_size, rd0_size};
  assign rd0_data = rdata[0];
  assign rd1_data = rdata[1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_rdport u_rd (
      .sel(rsel[p]), .size(rsize[p]), .act(bank_q[bank]),
      .pc_q(pc_q), .vb_q(vb_q), .us_q(us_q), .is_q(is_q), .sb_q(sb_q), .fl_q(fl_q),
      .data(rdata[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
(
  input logic                                clk,
  input logic                                rst_n,
  input logic                                wr_en,
  input logic [3:0]                          wr_sel,
  input logic [1:0]                          wr_size,
  input logic [31:0]                         wr_data,
  input logic                                wr_illegal,
  input logic                                wr_banked,
  input logic                                bank,
  input logic [NBANK-1:0][NBREG-1:0][DW-1:0] bank_q,
  input logic [NBREG-1:0]                    we_vec,
  input logic [PCW-1:0]                      pc_q,
  input logic [DW-1:0]                       fl_q,
  input logic [3:0]                          rd0_sel,
  input logic [1:0]                          rd0_size,
  input logic [31:0]                         rd0_data
);
  // R1: registers cleared when reset lifts
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bank_q == '0 && fl_q == '0 && pc_q == '0));

  // R5: the inactive bank never changes
  p_keep_bank1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bank) |=> $stable(bank_q[1]));
  p_keep_bank0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank) |=> $stable(bank_q[0]));

  // R3: a high-byte write to D0 keeps its low byte
  p_byte_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == S_D0 && wr_size == Z_HI) |=>
      bank_q[bank][0][7:0] == $past(bank_q[bank][0][7:0]));

  // R4: X1:X0 pair write lands in both halves at once
  p_pair_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == S_X0 && wr_size == Z_PAIR) |=>
      {bank_q[bank][5], bank_q[bank][4]} == $past(wr_data));

  // R4: a pair write enables exactly two banked registers
  p_pair_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_banked && wr_size == Z_PAIR) |-> $countones(we_vec) == 2);

  // R9: an illegal write changes nothing
  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |=> ($stable(bank_q) && $stable(fl_q) && $stable(pc_q)));

  // R7: undefined flag bits stay zero
  p_flag_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q & ~FLAG_MASK) == '0);

  // R6: program counter reads are 20 bits, zero-extended
  p_pc_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_sel == S_PC && rd0_size == Z_WORD) |-> rd0_data[31:PCW] == '0);
endmodule

bind dual_bank_rf rf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
  .wr_data(wr_data), .wr_illegal(wr_illegal), .wr_banked(wr_banked), .bank(bank),
  .bank_q(bank_q), .we_vec(we_vec), .pc_q(pc_q), .fl_q(fl_q),
  .rd0_sel(rd0_sel), .rd0_size(rd0_size), .rd0_data(rd0_data)
);

// File: tb/sim_dual_bank_rf.sv
module sim_dual_bank_rf;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  rd0_sel = 0, rd1_sel = 0, wr_sel = 0;
  logic [1:0]  rd0_size = 0, rd1_size = 0, wr_size = 0;
  logic [31:0] rd0_data, rd1_data, wr_data = 0;
  logic        wr_en = 0, bank_act;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_bank_rf u0 (.*);

  // Reference model
  logic [15:0] m_bank [2][7];
  logic [31:0] m_shr [7:12];

  function automatic logic m_ok(input logic [3:0] s, input logic [1:0] z);
    if (z == 0) return s < 13;
    if (z == 3) return s == 0 || s == 1 || s == 4;
    return s == 0 || s == 1;
  endfunction

  function automatic int m_part(input logic [3:0] s);
    return (s == 4) ? 5 : int'(s) + 2;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] s, input logic [1:0] z);
    int b = int'(m_shr[12][4]);
    if (!m_ok(s, z)) return 0;
    if (s >= 7) return m_shr[s];
    case (z)
      2'd1: return {24'd0, m_bank[b][s][7:0]};
      2'd2: return {24'd0, m_bank[b][s][15:8]};
      2'd3: return {m_bank[b][m_part(s)], m_bank[b][s]};
      default: return {16'd0, m_bank[b][s]};
    endcase
  endfunction

  task automatic m_write(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
    int b = int'(m_shr[12][4]);
    if (!m_ok(s, z)) return;
    if (s == 7 || s == 8) m_shr[s] = {12'd0, d[19:0]};
    else if (s == 12)     m_shr[s] = d & 32'h70FF;
    else if (s >= 9)      m_shr[s] = {16'd0, d[15:0]};
    else if (z == 1)      m_bank[b][s][7:0]  = d[7:0];
    else if (z == 2)      m_bank[b][s][15:8] = d[7:0];
    else begin
      m_bank[b][s] = d[15:0];
      if (z == 3) m_bank[b][m_part(s)] = d[31:16];
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [3:0] s, input logic [1:0] z);
    rd0_sel = s; rd0_size = z;
    #1;
    check(req, rd0_data, m_read(s, z));
  endtask

  task automatic wr(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_size = z; wr_data = d;
    @(posedge clk);
    m_write(s, z, d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 13; s++) rd("R1 reset", 4'(s), 2'd0);
    check("R1 bank after reset", {31'd0, bank_act}, 0);
  endtask

  task automatic t_banks;
    for (int s = 0; s < 7; s++) wr(4'(s), 0, 32'h1100 + s);
    wr(12, 0, 32'h10);
    check("R5 bank flag", {31'd0, bank_act}, 1);
    for (int s = 0; s < 7; s++) wr(4'(s), 0, 32'hFFFF_2200 + s);
    for (int s = 0; s < 7; s++) rd("R2 bank1 word", 4'(s), 0);
    rd("R2 explicit", 3, 0);
    check("R2 bank1 D3 value", rd0_data, 32'h2203);
    wr(12, 0, 0);
    for (int s = 0; s < 7; s++) rd("R5 bank0 kept", 4'(s), 0);
    rd("R5 explicit", 6, 0);
    check("R5 bank0 FBASE value", rd0_data, 32'h1106);
  endtask

  task automatic t_bytes;
    wr(1, 0, 32'hA5C3);
    wr(1, 1, 32'hFF7E);
    rd("R3 low write keeps high", 1, 0);
    check("R3 merged low", rd0_data, 32'hA57E);
    wr(1, 2, 32'h0019);
    rd("R3 high write keeps low", 1, 0);
    check("R3 merged high", rd0_data, 32'h197E);
    rd("R3 byte lo read", 1, 1);
    rd("R3 byte hi read", 1, 2);
    check("R3 byte hi zero-ext", rd0_data, 32'h19);
  endtask

  task automatic t_pairs;
    wr(0, 3, 32'hDEAD_BEEF);
    rd("R4 D2 upper", 2, 0);
    check("R4 D2 value", rd0_data, 32'hDEAD);
    rd("R4 D0 lower", 0, 0);
    wr(1, 3, 32'h1234_5678);
    rd("R4 D3D1 pair", 1, 3);
    wr(4, 3, 32'hCAFE_0042);
    rd("R4 X1 upper", 5, 0);
    check("R4 X1X0 pair", m_read(4, 3), 32'hCAFE_0042);
    rd("R4 X1X0 read", 4, 3);
  endtask

  task automatic t_shared;
    wr(7, 0, 32'hFFFF_FFFF);
    rd("R6 PCNT 20 bit", 7, 0);
    check("R6 PCNT value", rd0_data, 32'h000F_FFFF);
    wr(9, 0, 32'h1234_5678);
    wr(12, 0, 32'h10);
    rd("R6 USTK other bank", 9, 0);
    check("R6 USTK value", rd0_data, 32'h5678);
    wr(8, 0, 32'hABCDE);
    rd("R6 VBASE", 8, 0);
    wr(12, 0, 0);
    rd("R6 VBASE bank0", 8, 0);
  endtask

  task automatic t_flags;
    wr(12, 0, 32'hFFFF_FFFF);
    rd("R7 flag mask", 12, 0);
    check("R7 flag value", rd0_data, 32'h70FF);
    check("R7 bank bit", {31'd0, bank_act}, 1);
    rd("R7 bank1 visible", 0, 0);
    wr(12, 0, 0);
  endtask

  task automatic t_rdw;
    logic [31:0] oldv;
    wr(11, 0, 32'h1111);
    oldv = m_read(11, 0);
    @(negedge clk);
    wr_en = 1; wr_sel = 11; wr_size = 0; wr_data = 32'hBEEF;
    rd1_sel = 11; rd1_size = 0;
    #1;
    check("R8 old value during write", rd1_data, oldv);
    @(posedge clk);
    m_write(11, 0, 32'hBEEF);
    #1;
    check("R8 new value after edge", rd1_data, 32'hBEEF);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_illegal;
    wr(2, 1, 32'hFF);
    wr(2, 3, 32'h5555_5555);
    wr(7, 2, 32'h77);
    wr(14, 0, 32'h9999);
    rd("R9 D2 untouched", 2, 0);
    check("R9 D2 value", rd0_data, 32'hDEAD);
    rd("R9 PCNT untouched", 7, 0);
    rd("R9 illegal read", 3, 1);
    check("R9 illegal read zero", rd0_data, 0);
    rd("R9 selector 14", 14, 0);
    rd("R9 pair on D2", 2, 3);
  endtask

  task automatic t_ports;
    rd0_sel = 0; rd0_size = 3; rd1_sel = 1; rd1_size = 2;
    #1;
    check("R10 port0", rd0_data, m_read(0, 3));
    check("R10 port1", rd1_data, m_read(1, 2));
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int r = 0; r < 7; r++) m_bank[b][r] = 0;
    for (int s = 7; s < 13; s++) m_shr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_banks();
    t_bytes();
    t_pairs();
    t_shared();
    t_flags();
    t_rdw();
    t_illegal();
    t_ports();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule